// File: doc/BRIEF.md
# Serial Control Register Port

This block is a three-wire serial slave that sets up and reads back a bank of four control registers of unequal length: 11, 10, 8 and 10 bits at addresses 0 to 3. A host frames each transfer by pulling a load strobe low and toggling a serial clock. The data line is sampled on the rising clock edges. Each frame starts with a five-bit header: a direction flag (0 = write, 1 = read), then a test bit that must be 0, then a three-bit address sent least significant bit first. Register data follows, least significant bit first.

Written bits land in shadow copies. A write that runs past the last bit of a register carries on at bit 0 of the next higher address. Every register whose bits all arrived during the frame is copied to its active register together when the strobe rises. A read drives the addressed active register out on the data line, one bit per falling clock edge. The serial pins are oversampled in the system clock domain. The data line is split into an output value and an output enable, which the pad ring combines.

Register 0 holds two behaviour bits: bit 3 is a self-clearing software reset and bit 7 is a clamp enable. Bits 0 and 1 of register 0 always read 0 and bit 2 always reads 1, whatever is written to them.

Top module: `serial_regport`

## Requirements
- R1: After reset, `cfg0_q` is 0x004, `cfg1_q`, `cfg2_q` and `cfg3_q` are 0, and `sdo_en` is low.
- R2: A write frame with header bits 0,0 and address bits A0..A2 loads data bits LSB first. The active outputs do not change until the load strobe rises, and then they take the written value.
- R3: A continuous write moves on to D0 of the next higher address after exactly 11, 10, 8 or 10 bits for addresses 0 to 3. All registers completed in the frame update on the same strobe rise.
- R4: A register that did not receive all of its bits before the strobe rose keeps its previous active value.
- R5: Bits addressed to addresses 4 to 7, and bits clocked after the last bit of register 3, change no register.
- R6: A frame whose test bit is 1 writes nothing and never enables the data output.
- R7: When register 0 is committed, its bits 0 and 1 are forced to 0 and its bit 2 is forced to 1.
- R8: Committing register 0 with bit 3 set returns every active register to its reset value.
- R9: In a read frame the output enable goes high after the fifth falling serial clock edge. After falling edge 5+k the line carries bit k of the addressed active register. The enable drops after that register's last bit, and there is no auto-increment. The output is 0 whenever the enable is low.
- R10: A read of addresses 4 to 7 drives 11 zero bits.
- R11: A high load strobe clears the frame state, so a frame cut short by the strobe does not disturb the decoding of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sl | input | 1 | Load strobe; low during a frame, rising edge commits |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, from the shared data pin |
| sdo | output | 1 | Serial data out toward the shared data pin |
| sdo_en | output | 1 | Output enable for the shared data pin |
| cfg0_q | output | W0 | Active register 0 (bit 3 soft reset, bit 7 clamp enable) |
| cfg1_q | output | W1 | Active register 1 |
| cfg2_q | output | W2 | Active register 2 |
| cfg3_q | output | W3 | Active register 3 |

## Verification
A serial clock or strobe edge passes two synchronizer flops and one edge-detect flop. A rising strobe therefore shows on the active outputs four system clock edges later, and a falling serial clock edge updates `sdo`/`sdo_en` three edges later. The bench holds each serial clock phase for four system clocks and samples the outputs at the falling system clock edge that ends each low phase, which is after that update and before the next rising edge. After raising the strobe it waits eight clocks before it checks the registers. Register values are also checked while the strobe is still low, to show that nothing commits early.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int NREG = 4;
  localparam int AW   = 3;
  localparam int HDR  = 2 + AW;

  function automatic int reg_len(input int a, input int w0, input int w1,
                                 input int w2, input int w3);
    case (a)
      0:       return w0;
      1:       return w1;
      2:       return w2;
      3:       return w3;
      default: return 0;
    endcase
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int          N      = 3,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
      prev <= INIT;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/regport_frame.sv
module regport_frame
  import regport_pkg::*;
#(
  parameter int W0 = 11,
  parameter int W1 = 10,
  parameter int W2 = 8,
  parameter int W3 = 10,
  parameter int MW = 11,
  parameter int IW = 4,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sl_lvl,
  input  logic          sl_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          sdi,
  input  logic [MW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [IW-1:0] wr_bit,
  output logic          wr_val,
  output logic          wr_last,
  output logic          commit,
  output logic          sdo,
  output logic          sdo_en
);
  logic [CW-1:0] cnt_q;
  logic          rnw_q, tst_q;
  logic [AW-1:0] adr_q, cur_q, adr_nx;
  logic [IW-1:0] idx_q;
  logic          in_data, rd_bit;
  int            cur_len, rd_len, dpos;

  always_comb begin
    adr_nx = adr_q;
    for (int k = 0; k < AW; k++)
      if (cnt_q == CW'(k + 2)) adr_nx[k] = sdi;
    in_data = (cnt_q >= CW'(HDR));
    cur_len = reg_len(int'(cur_q), W0, W1, W2, W3);
    rd_len  = (int'(adr_q) < NREG) ? reg_len(int'(adr_q), W0, W1, W2, W3) : MW;
    dpos    = int'(cnt_q) - HDR;
    rd_bit  = 1'b0;
    for (int k = 0; k < MW; k++)
      if (dpos == k) rd_bit = rd_word[k];
  end

  always_ff @(posedge clk) begin
    if (rst || sl_lvl) begin
      cnt_q   <= '0;
      rnw_q   <= 1'b0;
      tst_q   <= 1'b0;
      adr_q   <= '0;
      cur_q   <= '0;
      idx_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_bit  <= '0;
      wr_val  <= 1'b0;
      wr_last <= 1'b0;
      sdo     <= 1'b0;
      sdo_en  <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      wr_last <= 1'b0;
      if (sck_rise) begin
        if (cnt_q != '1) cnt_q <= cnt_q + CW'(1);
        if (cnt_q == '0) rnw_q <= sdi;
        if (cnt_q == CW'(1)) tst_q <= sdi;
        adr_q <= adr_nx;
        if (cnt_q == CW'(HDR - 1)) begin
          cur_q <= adr_nx;
          idx_q <= '0;
        end
        if (in_data && !rnw_q && !tst_q && int'(cur_q) < NREG) begin
          wr_en   <= 1'b1;
          wr_addr <= cur_q;
          wr_bit  <= idx_q;
          wr_val  <= sdi;
          if (int'(idx_q) == cur_len - 1) begin
            wr_last <= 1'b1;
            idx_q   <= '0;
            cur_q   <= cur_q + AW'(1);
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
      end
      if (sck_fall) begin
        if (in_data && rnw_q && !tst_q && dpos < rd_len) begin
          sdo_en <= 1'b1;
          sdo    <= rd_bit;
        end else begin
          sdo_en <= 1'b0;
          sdo    <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) commit <= 1'b0;
    else     commit <= sl_rise;
  end

  assign rd_addr = adr_q;
endmodule

// File: rtl/regport_bank.sv
module regport_bank
  import regport_pkg::*;
#(
  parameter int          W0        = 11,
  parameter int          W1        = 10,
  parameter int          W2        = 8,
  parameter int          W3        = 10,
  parameter int          MW        = 11,
  parameter int          IW        = 4,
  parameter int unsigned R0_CLEAR  = 3,
  parameter int unsigned R0_SET    = 4,
  parameter int          SRST_BIT  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [IW-1:0]            wr_bit,
  input  logic                     wr_val,
  input  logic                     wr_last,
  input  logic                     commit,
  output logic [NREG-1:0][MW-1:0]  act_o
);
  logic [MW-1:0]   act_q [NREG];
  logic [MW-1:0]   shd_q [NREG];
  logic [NREG-1:0] full_q;

  function automatic logic [MW-1:0] rst_val(input int i);
    return (i == 0) ? MW'(R0_SET) : '0;
  endfunction

  function automatic logic [MW-1:0] settle(input int i, input logic [MW-1:0] v);
    if (i == 0) return (v & ~MW'(R0_CLEAR)) | MW'(R0_SET);
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        act_q[i] <= rst_val(i);
        shd_q[i] <= rst_val(i);
      end
      full_q <= '0;
    end else if (commit) begin
      if (full_q[0] && shd_q[0][SRST_BIT]) begin
        for (int i = 0; i < NREG; i++) begin
          act_q[i] <= rst_val(i);
          shd_q[i] <= rst_val(i);
        end
      end else begin
        for (int i = 0; i < NREG; i++) begin
          if (full_q[i]) begin
            act_q[i] <= settle(i, shd_q[i]);
            shd_q[i] <= settle(i, shd_q[i]);
          end else begin
            shd_q[i] <= act_q[i];
          end
        end
      end
      full_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        for (int k = 0; k < MW; k++)
          if (wr_addr == AW'(i) && wr_bit == IW'(k)) shd_q[i][k] <= wr_val;
        if (wr_last && wr_addr == AW'(i)) full_q[i] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign act_o[g] = act_q[g];
  end
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import regport_pkg::*;
#(
  parameter int          W0       = 11,
  parameter int          W1       = 10,
  parameter int          W2       = 8,
  parameter int          W3       = 10,
  parameter int unsigned R0_CLEAR = 3,
  parameter int unsigned R0_SET   = 4,
  parameter int          SRST_BIT = 3,
  parameter int          SYNC     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sl,
  input  logic          sck,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_en,
  output logic [W0-1:0] cfg0_q,
  output logic [W1-1:0] cfg1_q,
  output logic [W2-1:0] cfg2_q,
  output logic [W3-1:0] cfg3_q
);
  localparam int MW = max4(W0, W1, W2, W3);
  localparam int IW = $clog2(MW);
  localparam int CW = $clog2(HDR + MW + 2);

  logic [2:0]               s_lvl, s_rise, s_fall;
  logic [AW-1:0]            rd_addr, wr_addr;
  logic [IW-1:0]            wr_bit;
  logic                     wr_en, wr_val, wr_last, commit;
  logic [MW-1:0]            rd_word;
  logic [NREG-1:0][MW-1:0]  act;

  regport_sync #(.N(3), .STAGES(SYNC), .INIT(3'b100)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({sl, sck, sdi}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  regport_frame #(.W0(W0), .W1(W1), .W2(W2), .W3(W3), .MW(MW), .IW(IW), .CW(CW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sl_lvl   (s_lvl[2]),
    .sl_rise  (s_rise[2]),
    .sck_rise (s_rise[1]),
    .sck_fall (s_fall[1]),
    .sdi      (s_lvl[0]),
    .rd_word  (rd_word),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bit   (wr_bit),
    .wr_val   (wr_val),
    .wr_last  (wr_last),
    .commit   (commit),
    .sdo      (sdo),
    .sdo_en   (sdo_en)
  );

  regport_bank #(.W0(W0), .W1(W1), .W2(W2), .W3(W3), .MW(MW), .IW(IW),
                 .R0_CLEAR(R0_CLEAR), .R0_SET(R0_SET), .SRST_BIT(SRST_BIT)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_bit),
    .wr_val  (wr_val),
    .wr_last (wr_last),
    .commit  (commit),
    .act_o   (act)
  );

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_word = act[i];
  end

  assign cfg0_q = act[0][W0-1:0];
  assign cfg1_q = act[1][W1-1:0];
  assign cfg2_q = act[2][W2-1:0];
  assign cfg3_q = act[3][W3-1:0];
endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk #(
  parameter int          W0       = 11,
  parameter int          W1       = 10,
  parameter int          W2       = 8,
  parameter int          W3       = 10,
  parameter int unsigned R0_CLEAR = 3,
  parameter int unsigned R0_SET   = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sl,
  input logic          sdo,
  input logic          sdo_en,
  input logic [W0-1:0] cfg0_q,
  input logic [W1-1:0] cfg1_q,
  input logic [W2-1:0] cfg2_q,
  input logic [W3-1:0] cfg3_q
);
  logic [W0+W1+W2+W3-1:0] all_cfg;
  assign all_cfg = {cfg0_q, cfg1_q, cfg2_q, cfg3_q};

  // Active registers move only four edges after a strobe rise (R2)
  assert_commit_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(all_cfg) |-> ($past(sl, 4) && !$past(sl, 5)));

  // Fixed bits of register 0 always hold their forced values (R7)
  assert_fixed_bits_R7: assert property (@(posedge clk) disable iff (rst)
    ((cfg0_q & W0'(R0_CLEAR)) == '0) && ((cfg0_q & W0'(R0_SET)) == W0'(R0_SET)));

  // Output enable only rises inside a frame (R9)
  assert_enable_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> (!sl && !$past(sl)));

  // Output value is quiet while not enabled (R9)
  assert_quiet_output_R9: assert property (@(posedge clk) disable iff (rst)
    !sdo_en |-> !sdo);

  // A held-high strobe releases the line (R11)
  assert_strobe_releases_R11: assert property (@(posedge clk) disable iff (rst)
    (sl && $past(sl) && $past(sl, 2) && $past(sl, 3)) |-> !sdo_en);
endmodule

bind serial_regport serial_regport_chk #(
  .W0(W0), .W1(W1), .W2(W2), .W3(W3), .R0_CLEAR(R0_CLEAR), .R0_SET(R0_SET)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sl     (sl),
  .sdo    (sdo),
  .sdo_en (sdo_en),
  .cfg0_q (cfg0_q),
  .cfg1_q (cfg1_q),
  .cfg2_q (cfg2_q),
  .cfg3_q (cfg3_q)
);

// File: tb/sim_serial_regport.sv
module sim_serial_regport;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic sl  = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_en;
  logic [10:0] cfg0_q;
  logic [9:0]  cfg1_q;
  logic [7:0]  cfg2_q;
  logic [9:0]  cfg3_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_regport u0 (
    .clk(clk), .rst(rst), .sl(sl), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en),
    .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .cfg3_q(cfg3_q)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clkn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift one frame; rlen >= 0 enables readback observation after each falling edge
  task automatic shift(input logic rnw, input logic tb, input int adr,
                       input logic [63:0] data, input int nbits,
                       input int rlen, input logic [63:0] rexp, output int bad);
    logic [79:0] seq;
    int total;
    seq = '0;
    seq[0] = rnw;
    seq[1] = tb;
    seq[2] = adr[0];
    seq[3] = adr[1];
    seq[4] = adr[2];
    for (int j = 0; j < nbits; j++) seq[5+j] = data[j];
    total = 5 + nbits;
    bad = 0;
    sl = 1'b0;
    clkn(4);
    for (int j = 0; j < total; j++) begin
      logic ee;
      sdi = seq[j];
      clkn(4);
      if (rlen >= 0 && j >= 1) begin
        ee = (j >= 5 && j < 5 + rlen);
        if (sdo_en !== ee) bad++;
        else if (ee && sdo !== rexp[j-5]) bad++;
      end
      sck = 1'b1;
      clkn(4);
      sck = 1'b0;
    end
    clkn(4);
  endtask

  task automatic end_frame();
    sl = 1'b1;
    clkn(8);
  endtask

  task automatic wr(input int adr, input logic [63:0] data, input int n);
    int bad;
    shift(1'b0, 1'b0, adr, data, n, -1, '0, bad);
  endtask

  task automatic rd_chk(input string req, input int adr, input int w, input logic [63:0] exp);
    int bad;
    shift(1'b1, 1'b0, adr, '0, w + 1, w, exp, bad);
    end_frame();
    check(req, bad, 0);
  endtask

  task automatic t_reset();
    check("R1 cfg0", cfg0_q, 64'h004);
    check("R1 cfg1", cfg1_q, 0);
    check("R1 cfg2", cfg2_q, 0);
    check("R1 cfg3", cfg3_q, 0);
    check("R1 sdo_en", sdo_en, 0);
  endtask

  task automatic t_single();
    wr(2, 64'hA7, 8);
    check("R2 held before strobe", cfg2_q, 0);
    end_frame();
    check("R2 committed", cfg2_q, 64'hA7);
  endtask

  task automatic t_fixed();
    wr(0, 64'h7F7, 11);
    end_frame();
    check("R7 forced bits", cfg0_q, 64'h7F4);
    rd_chk("R9 read reg0", 0, 11, 64'h7F4);
  endtask

  task automatic t_chain();
    // 10 + 8 + 10 bits from address 1, then 5 surplus ones (R3, R5)
    wr(1, {31'h0, 5'h1F, 10'h15A, 8'hC3, 10'h2A5}, 33);
    check("R3 held reg1", cfg1_q, 0);
    check("R3 held reg3", cfg3_q, 0);
    end_frame();
    check("R3 reg1", cfg1_q, 64'h2A5);
    check("R3 reg2", cfg2_q, 64'hC3);
    check("R5 surplus ignored reg3", cfg3_q, 64'h15A);
    check("R3 reg0 untouched", cfg0_q, 64'h7F4);
  endtask

  task automatic t_read();
    rd_chk("R9 read reg2", 2, 8, 64'hC3);
    rd_chk("R9 read reg3 no increment", 3, 10, 64'h15A);
  endtask

  task automatic t_unused();
    rd_chk("R10 read addr6 zeros", 6, 11, 64'h0);
  endtask

  task automatic t_partial();
    wr(2, 64'h1F, 5);
    end_frame();
    check("R4 partial reg2", cfg2_q, 64'hC3);
    wr(0, {49'h0, 4'hF, 11'h0F0}, 15);
    end_frame();
    check("R4 full reg0", cfg0_q, 64'h0F4);
    check("R4 partial reg1", cfg1_q, 64'h2A5);
  endtask

  task automatic t_beyond();
    wr(5, 64'h3FF, 10);
    end_frame();
    check("R5 addr5 reg0", cfg0_q, 64'h0F4);
    check("R5 addr5 reg1", cfg1_q, 64'h2A5);
    check("R5 addr5 reg2", cfg2_q, 64'hC3);
    check("R5 addr5 reg3", cfg3_q, 64'h15A);
  endtask

  task automatic t_testbit();
    int bad;
    shift(1'b0, 1'b1, 1, 64'h111, 10, -1, '0, bad);
    end_frame();
    check("R6 write ignored", cfg1_q, 64'h2A5);
    shift(1'b1, 1'b1, 1, '0, 11, 0, '0, bad);
    end_frame();
    check("R6 read never drives", bad, 0);
  endtask

  task automatic t_abort();
    int bad;
    shift(1'b1, 1'b1, 7, '0, -2, -1, '0, bad);
    end_frame();
    wr(3, 64'h0F0, 10);
    end_frame();
    check("R11 fresh frame", cfg3_q, 64'h0F0);
    check("R11 others intact", cfg2_q, 64'hC3);
  endtask

  task automatic t_srst();
    wr(0, 64'h008, 11);
    end_frame();
    check("R8 reg0", cfg0_q, 64'h004);
    check("R8 reg1", cfg1_q, 0);
    check("R8 reg2", cfg2_q, 0);
    check("R8 reg3", cfg3_q, 0);
    rd_chk("R8 readback reg1", 1, 10, 64'h0);
  endtask

  initial begin
    clkn(5);
    rst = 1'b0;
    clkn(3);
    t_reset();
    t_single();
    t_fixed();
    t_chain();
    t_read();
    t_unused();
    t_partial();
    t_beyond();
    t_testbit();
    t_abort();
    t_srst();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule